// File: doc/BRIEF.md
# Sampling Converter Host Controller

This block drives a sampling converter from the host side. The converter has one start pin, a busy output and an 8-bit read port that carries a 10-bit result in two parts. The controller starts one conversion per sample period. It waits for busy to fall, then issues two read strobes and joins the two bytes into a 10-bit sample, which it presents with a one-cycle valid strobe.

A conversion begins on the falling edge of the start output. Each sample starts with a high phase of `ARM_CYC` cycles, which gives the converter time to power up. The mode input decides what the start output does after that falling edge. In high-speed mode (mode = 0) the start output returns high a few cycles later and stays high through the end of conversion, so the converter stays powered. In power-down mode (mode = 1) the start output stays low until the next sample, so the converter powers down when each conversion ends.

The sample period is measured in clock cycles. It is raised to a minimum so that a new conversion never overlaps the conversion and reads of the previous one. If busy stays high for too long, the controller stops waiting, raises an error flag and returns to idle.

Top module: `cnv_seq_ctrl`

## Requirements
- R1: When a sample launches, `start_o` is driven high for exactly `ARM_CYC` cycles and then falls. The conversion is triggered by that falling edge.
- R2: In high-speed mode (`mode_i` = 0 at launch), `start_o` returns high `LOW_CYC` (at least 1) cycles after its falling edge. It stays high when busy falls and through the idle time that follows.
- R3: In power-down mode (`mode_i` = 1 at launch), `start_o` stays low from its falling edge until the next launch, so it is low when busy falls.
- R4: Read strobes appear only after a high-to-low transition of `busy_i` is seen while the controller is waiting for it. Each sample gets two strobes, each high for `RD_CYC` cycles, with `GAP_CYC` low cycles between them.
- R5: The data byte is captured on the last cycle of each strobe. `sample_o` = {first byte, second byte bits [7:6]}, and bits [5:0] of the second byte are ignored.
- R6: `sample_vld_o` is high for exactly one cycle: the cycle that follows the capture of the second byte.
- R7: Successive falling edges of `start_o` are `max(period_i, MIN_PER)` cycles apart, with MIN_PER = ARM_CYC + CONV_CYC + 2·RD_CYC + GAP_CYC + 2.
- R8: If busy has not fallen `TMO_CYC` cycles after the start falling edge, `tmo_err_o` goes high at that point. No reads follow, and the controller returns to idle. `tmo_err_o` clears when the next sample becomes valid.
- R9: While `en` is low, no sample launches. The period counter saturates, so the first sample after `en` rises launches on the next clock edge once the period has already elapsed.
- R10: After reset, `start_o`, `rd_strb_o`, `sample_vld_o` and `tmo_err_o` are low and `sample_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows new samples to launch |
| period_i | input | PW | Sample period in clock cycles (raised to MIN_PER) |
| mode_i | input | 1 | 0 = high-speed, 1 = power-down between samples |
| busy_i | input | 1 | Converter busy; its falling edge marks end of conversion |
| rd_data_i | input | 8 | Converter read port byte |
| start_o | output | 1 | Conversion start to the converter |
| rd_strb_o | output | 1 | Read strobe to the converter |
| sample_o | output | 10 | Last assembled sample |
| sample_vld_o | output | 1 | One-cycle pulse when `sample_o` is updated |
| tmo_err_o | output | 1 | Busy did not fall in time |

## Verification
The bench builds the controller with an 8-bit period, a 3-cycle arm phase, 2-cycle read strobes, a 1-cycle gap and a nominal conversion time of 12 cycles, which gives MIN_PER = 22. It uses a 40-cycle timeout. With these values, periods below the minimum are clamped, and a full 255-cycle period fits in a short run. A stuck busy trips the timeout quickly enough to check the exact cycle of the error. The converter model ends each conversion 10 cycles after the start falling edge. It fills the unused low bits of the second byte with a nonzero pattern, so any leak of those bits into the sample shows up.

// File: rtl/cnv_seq_ctrl.sv
module cnv_seq_ctrl #(
  parameter int PW       = 16,
  parameter int ARM_CYC  = 50,
  parameter int LOW_CYC  = 4,
  parameter int CONV_CYC = 120,
  parameter int RD_CYC   = 3,
  parameter int GAP_CYC  = 2,
  parameter int TMO_CYC  = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] period_i,
  input  logic          mode_i,
  input  logic          busy_i,
  input  logic [7:0]    rd_data_i,
  output logic          start_o,
  output logic          rd_strb_o,
  output logic [9:0]    sample_o,
  output logic          sample_vld_o,
  output logic          tmo_err_o
);

  localparam int MIN_PER = ARM_CYC + CONV_CYC + 2*RD_CYC + GAP_CYC + 2;
  localparam int CW = $clog2(TMO_CYC + ARM_CYC + RD_CYC + GAP_CYC + LOW_CYC + 2) + 1;

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_CONV, S_RD1, S_GAP, S_RD2} st_t;

  st_t           st, st_n;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pcnt;
  logic          hs_q, busy_q, vld_q, err_q;
  logic [7:0]    hi_q;
  logic [9:0]    smp_q;

  wire [PW-1:0] min_per   = PW'(MIN_PER);
  wire [PW-1:0] eff_per   = (period_i < min_per) ? min_per : period_i;
  wire          launch    = (st == S_IDLE) && en && (pcnt >= eff_per - 1'b1);
  wire          busy_fall = busy_q & ~busy_i;
  wire          rd_last   = (cnt == CW'(RD_CYC - 1));
  wire          tmo_hit   = (st == S_CONV) && !busy_fall && (cnt == CW'(TMO_CYC - 1));

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE: if (launch) st_n = S_ARM;
      S_ARM:  if (cnt == CW'(ARM_CYC - 1)) st_n = S_CONV;
      S_CONV: if (busy_fall) st_n = S_RD1;
              else if (tmo_hit) st_n = S_IDLE;
      S_RD1:  if (rd_last) st_n = S_GAP;
      S_GAP:  if (cnt == CW'(GAP_CYC - 1)) st_n = S_RD2;
      S_RD2:  if (rd_last) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      pcnt   <= '1;
      hs_q   <= 1'b0;
      busy_q <= 1'b0;
      hi_q   <= '0;
      smp_q  <= '0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st     <= st_n;
      cnt    <= (st_n != st) ? '0 : cnt + 1'b1;
      busy_q <= busy_i;
      vld_q  <= 1'b0;
      if (launch) begin
        pcnt <= '0;
        hs_q <= ~mode_i;
      end else if (pcnt != '1) begin
        pcnt <= pcnt + 1'b1;
      end
      if (st == S_RD1 && rd_last) hi_q <= rd_data_i;
      if (st == S_RD2 && rd_last) begin
        smp_q <= {hi_q, rd_data_i[7:6]};
        vld_q <= 1'b1;
        err_q <= 1'b0;
      end
      if (tmo_hit) err_q <= 1'b1;
    end
  end

  assign start_o      = (st == S_ARM) || (hs_q && !(st == S_CONV && cnt < CW'(LOW_CYC)));
  assign rd_strb_o    = (st == S_RD1) || (st == S_RD2);
  assign sample_o     = smp_q;
  assign sample_vld_o = vld_q;
  assign tmo_err_o    = err_q;

  a_r1_fall_ends_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_o) |-> $past(st) == S_ARM);

  a_r2_hs_high_at_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV && busy_fall && hs_q) |-> start_o);

  a_r3_pd_low_at_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV && busy_fall && !hs_q) |-> !start_o);

  a_r4_no_read_before_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV && !busy_fall) |=> !rd_strb_o);

  a_r6_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld_o |=> !sample_vld_o);

  a_r7_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && st_n == S_ARM) |-> pcnt >= min_per - 1'b1);

  a_r8_tmo_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err_o) |-> (st == S_IDLE && !rd_strb_o));

endmodule

// File: tb/cnv_seq_ctrl_tb_top.sv
module cnv_seq_ctrl_tb_top;
  localparam int PW = 8, ARM = 3, LOW = 2, CONV = 12, RD = 2, GAP = 1, TMO = 40;
  localparam int MINP  = ARM + CONV + 2*RD + GAP + 2;
  localparam int MCONV = 10;
  localparam int NV    = 7;
  // {mode, period, value}
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 8'd30,  10'h2A5},
    {1'b1, 8'd30,  10'h15A},
    {1'b0, 8'd5,   10'h3FF},
    {1'b1, 8'd0,   10'h001},
    {1'b0, 8'd22,  10'h200},
    {1'b0, 8'd255, 10'h37E},
    {1'b1, 8'd60,  10'h0C3}
  };

  logic clk = 0, rst_n = 0, en = 0, mode = 0, busy = 0;
  logic [PW-1:0] period = 8'd30;
  logic [7:0] rd_data = 0;
  wire start, strb, vld, err;
  wire [9:0] sample;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  cnv_seq_ctrl #(.PW(PW), .ARM_CYC(ARM), .LOW_CYC(LOW), .CONV_CYC(CONV),
                 .RD_CYC(RD), .GAP_CYC(GAP), .TMO_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .period_i(period), .mode_i(mode),
    .busy_i(busy), .rd_data_i(rd_data), .start_o(start), .rd_strb_o(strb),
    .sample_o(sample), .sample_vld_o(vld), .tmo_err_o(err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int cyc = 0, falls = 0, last_fall = 0, fall_gap = 0;
  int strb_run = 0, strb_idx = 0, strb_total = 0, mcnt = 0;
  bit st_p = 0, sb_p = 0, vld_p = 0, stuck = 0, lvl_eoc = 0;
  logic [9:0] mdl_val = 0, lat = 0;

  // monitor and converter model, both away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (st_p && !start) begin
      falls++;
      fall_gap = cyc - last_fall;
      last_fall = cyc;
    end
    if (strb) begin
      strb_run++;
      if (!sb_p) begin
        strb_idx++;
        strb_total++;
        chk(!busy, "R4 strobe while busy", 1, 0);
        rd_data = (strb_idx == 1) ? lat[9:2] : {lat[1:0], 6'b110101};
      end
    end
    if (!strb && sb_p) begin
      chk(strb_run == RD, "R4 strobe width", strb_run, RD);
      if (strb_idx == 2) chk(vld, "R6 valid after second read", vld, 1);
      strb_run = 0;
    end
    if (vld && vld_p) chk(0, "R6 valid longer than one cycle", 2, 1);
    if (st_p && !start) begin
      busy = 1;
      mcnt = MCONV;
    end else if (busy && !stuck) begin
      mcnt--;
      if (mcnt == 0) begin
        busy = 0;
        lat = mdl_val;
        lvl_eoc = start;
        strb_idx = 0;
      end
    end
    st_p = start;
    sb_p = strb;
    vld_p = vld;
  end

  task automatic wait_vld(output bit got);
    got = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (vld) begin
        got = 1;
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit got;
    int f0, s0, expg;
    logic [9:0] v;
    repeat (3) @(negedge clk);
    chk(!start && !strb && !vld && !err, "R10 reset outputs", {start, strb, vld, err}, 0);
    chk(sample == 0, "R10 reset sample", sample, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(falls == 0 && !start, "R9 no launch while disabled", falls, 0);

    for (int k = 0; k < NV; k++) begin
      mode = VEC[k][18];
      period = VEC[k][17:10];
      v = VEC[k][9:0];
      mdl_val = v;
      en = 1;
      wait_vld(got);
      chk(got && sample == v, "R5 sample assembly", sample, v);
      chk(lvl_eoc == !mode, mode ? "R3 start low at end of conversion" : "R2 start high at end of conversion", lvl_eoc, !mode);
      chk(start == !mode, mode ? "R3 idle start level" : "R2 idle start level", start, !mode);
      mdl_val = ~v;
      wait_vld(got);
      chk(got && sample == ~v, "R5 sample assembly second", sample, ~v);
      expg = (int'(period) < MINP) ? MINP : int'(period);
      chk(fall_gap == expg, "R7 start spacing", fall_gap, expg);
    end

    en = 0;
    mode = 1;
    period = 8'd100;
    f0 = falls;
    repeat (200) @(negedge clk);
    chk(falls == f0, "R9 disabled no starts", falls - f0, 0);
    mdl_val = 10'h2C9;
    en = 1;
    @(negedge clk);
    chk(start, "R9 immediate launch / R1 start raised", start, 1);
    repeat (ARM - 1) @(negedge clk);
    chk(start, "R1 start high through arm phase", start, 1);
    @(negedge clk);
    chk(!start, "R1 start falls after arm phase", start, 0);
    wait_vld(got);
    chk(got && sample == 10'h2C9, "R5 sample after enable", sample, 10'h2C9);

    mode = 0;
    period = 8'd30;
    stuck = 1;
    s0 = strb_total;
    for (int i = 0; i < 300 && !start; i++) @(negedge clk);
    for (int i = 0; i < 300 && start; i++) @(negedge clk);
    repeat (TMO - 1) @(negedge clk);
    chk(!err, "R8 no error before timeout", err, 0);
    @(negedge clk);
    chk(err, "R8 error at timeout", err, 1);
    chk(strb_total == s0, "R8 no reads after timeout", strb_total - s0, 0);
    mdl_val = 10'h155;
    stuck = 0;
    wait_vld(got);
    chk(got && sample == 10'h155, "R8 recovery sample", sample, 10'h155);
    chk(!err, "R8 error cleared by valid sample", err, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule